// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the device from power-on to normal operation. After reset it holds the clock enable low and keeps the chip deselected for a long settling wait. It then raises the clock enable and sends NOP commands for a second wait, and closes every bank with one precharge-all. Next it runs a short burst of auto-refresh commands and loads the mode register. When all of that is done it raises `ready`.

The refresh burst does not come from a fixed count of commands. For a fixed window the sequencer runs its periodic refresh timer with a very short interval of two 16-clock units. When the window closes, the timer is switched to the working interval. That interval is derived from a 7513 ns target and rounded down, so it never exceeds the target. It then keeps requesting one auto-refresh per expiry, for as long as the block is out of reset. Every wait is a parameter counted in clock cycles. The nanosecond gaps are converted to cycles by rounding up at the configured clock rate.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, and for PWR_WAIT_CYC cycles after it is released, `sd_cke` is 0 and the command pins show inhibit (`sd_cs_n`=1, command code {cs_n,ras_n,cas_n,we_n}=4'b1111). `ready` is 0 during this time.
- R2: `sd_cke` rises exactly PWR_WAIT_CYC clock edges after reset release and stays 1 until the next reset. From that edge on, the idle command is NOP (4'b0111).
- R3: Precharge-all (4'b0010) with address bit 10 set is issued once, NOP_WAIT_CYC edges after the clock enable rises.
- R4: The refresh burst window lasts BURST_WIN_CYC cycles from the precharge. Within it, an auto-refresh (4'b0001) goes out 33 cycles after the precharge and then every 32 cycles (2 units of 16 clocks), up to and including the window's last edge.
- R5: A mode-register load (4'b0000) is issued once with address = 0x033: burst length 8 (A2..A0=011), sequential (A3=0), CAS latency 3 (A6..A4=011). The bank bits are 0.
- R6: No command follows another before its gap has passed: tRP = ceil(24 ns) after precharge, tRFC = ceil(70 ns) after refresh, 2 cycles after the mode load. The mode load goes out on the first edge that is after the window, at least tRFC after the last refresh and at least tRP after the precharge.
- R7: `ready` rises exactly 2 cycles after the mode load and stays 1 until reset.
- R8: Once ready, auto-refresh repeats every 16*floor(floor(7513*CLK_MHZ/1000)/16) cycles. The first one comes one cycle after the first interval has elapsed. The interval in time never exceeds 7513 ns.
- R9: Apart from the commands above, the pins carry only NOP after the clock enable rises.
- R10: Asserting reset at any point returns the outputs at once to the R1 state, and the whole sequence then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select, held at 0 |
| sd_addr | output | ADDR_W | Address pins (A10 for precharge-all, mode word for the load) |
| ready | output | 1 | Initialization complete |

## Verification
The scoreboard predicts every non-NOP command with its exact clock edge and address, derived from the cycle budget. The first run goes through the whole sequence and three working-interval refreshes. This tells apart the 32-cycle burst spacing, the mode-load placement against the refresh recovery, and the rounded-down working interval. A second run resets the block in the middle of the refresh burst. It then checks that the outputs fall back at once and that a fresh sequence matches the same prediction. That separates a true restart from state left over from the earlier run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // command code on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111,
    CMD_INH = 4'b1111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    S_PWR, S_NOP, S_BURST, S_DRAIN, S_MRDW, S_RUN
  } seq_state_e;

  localparam int UNIT_CLKS = 16;

  // nanoseconds to cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // refresh interval in 16-clock units, rounded down so it never runs long
  function automatic int refi_units(input int ns, input int mhz);
    return ((ns * mhz) / 1000) / UNIT_CLKS;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             idle
);
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val - 1'b1;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/sdram_refi_timer.sv
module sdram_refi_timer #(
  parameter int UNIT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [UNIT_W-1:0] units,
  input  logic              ack,
  output logic              pending
);
  localparam int CW = UNIT_W + 4;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = {units, 4'b0000} - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (!en) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (cnt == last) begin
      cnt     <= '0;
      pending <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ       = 108,
  parameter int PWR_WAIT_CYC  = 10_800_000,
  parameter int NOP_WAIT_CYC  = 21_600_000,
  parameter int BURST_WIN_CYC = 256,
  parameter int BURST_UNITS   = 2,
  parameter int TRP_NS        = 24,
  parameter int TRFC_NS       = 70,
  parameter int TMRD_CYC      = 2,
  parameter int REFI_NS       = 7513,
  parameter int MODE_WORD     = 'h033,
  parameter int ADDR_W        = 13,
  parameter int BA_W          = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              ready
);
  localparam int TRP_CYC   = ns_to_cyc(TRP_NS, CLK_MHZ);
  localparam int TRFC_CYC  = ns_to_cyc(TRFC_NS, CLK_MHZ);
  localparam int RUN_UNITS = refi_units(REFI_NS, CLK_MHZ);
  localparam int LONGEST   = max3(PWR_WAIT_CYC, NOP_WAIT_CYC, BURST_WIN_CYC);
  localparam int CNT_W     = $clog2(LONGEST + 1);
  localparam int GAP_W     = $clog2(max3(TRP_CYC, TRFC_CYC, TMRD_CYC) + 1) + 1;
  localparam int UNIT_W    = $clog2(max3(RUN_UNITS, BURST_UNITS, 1) + 1);
  localparam int A10       = 10;

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  sdr_cmd_e          cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cke_q;
  logic              ready_q;

  // named internal events
  logic              wait_end;
  logic              issue_pre;
  logic              issue_ref;
  logic              issue_mrs;
  logic              gap_idle;
  logic              ref_pending;
  logic              refi_en;
  logic [UNIT_W-1:0] refi_units_sel;
  logic [GAP_W-1:0]  gap_val;

  always_comb begin
    unique case (state)
      S_PWR:   wait_end = (cnt == CNT_W'(PWR_WAIT_CYC - 1));
      S_NOP:   wait_end = (cnt == CNT_W'(NOP_WAIT_CYC - 1));
      S_BURST: wait_end = (cnt == CNT_W'(BURST_WIN_CYC - 1));
      default: wait_end = 1'b0;
    endcase
  end

  assign issue_pre = (state == S_NOP) && wait_end;
  assign issue_ref = ((state == S_BURST) || (state == S_RUN)) && ref_pending && gap_idle;
  assign issue_mrs = (state == S_DRAIN) && gap_idle;

  assign refi_en        = (state == S_BURST) || (state == S_RUN);
  assign refi_units_sel = (state == S_RUN) ? UNIT_W'(RUN_UNITS) : UNIT_W'(BURST_UNITS);

  always_comb begin
    if (issue_pre)      gap_val = GAP_W'(TRP_CYC);
    else if (issue_ref) gap_val = GAP_W'(TRFC_CYC);
    else                gap_val = GAP_W'(TMRD_CYC);
  end

  sdram_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue_pre | issue_ref | issue_mrs),
    .load_val (gap_val),
    .idle     (gap_idle)
  );

  sdram_refi_timer #(.UNIT_W(UNIT_W)) u_refi (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (refi_en),
    .units   (refi_units_sel),
    .ack     (issue_ref),
    .pending (ref_pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_PWR;
      cnt     <= '0;
      cmd_q   <= CMD_INH;
      addr_q  <= '0;
      cke_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      unique case (state)
        S_PWR: begin
          if (wait_end) begin
            state <= S_NOP;
            cnt   <= '0;
            cke_q <= 1'b1;
          end else begin
            cnt   <= cnt + 1'b1;
            cmd_q <= CMD_INH;
          end
        end
        S_NOP: begin
          if (issue_pre) begin
            cmd_q  <= CMD_PRE;
            addr_q <= ADDR_W'(1) << A10;
            state  <= S_BURST;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BURST: begin
          if (issue_ref) cmd_q <= CMD_REF;
          if (wait_end) begin
            state <= S_DRAIN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DRAIN: begin
          if (issue_mrs) begin
            cmd_q  <= CMD_LMR;
            addr_q <= ADDR_W'(MODE_WORD);
            state  <= S_MRDW;
          end
        end
        S_MRDW: begin
          if (gap_idle) begin
            state   <= S_RUN;
            ready_q <= 1'b1;
          end
        end
        S_RUN: begin
          if (issue_ref) cmd_q <= CMD_REF;
        end
        default: state <= S_PWR;
      endcase
    end
  end

  assign sd_cke   = cke_q;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr  = addr_q;
  assign sd_ba    = '0;
  assign ready    = ready_q;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int TRP_C      = 3,
  parameter int TRFC_C     = 8,
  parameter int TMRD_C     = 2,
  parameter int RUN_PERIOD = 800,
  parameter int MODE       = 'h033
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              ready,
  input logic              issue_ref,
  input logic              issue_mrs
);
  logic [3:0]  pin_cmd;
  logic        is_cmd;
  logic [15:0] since;
  logic [15:0] need;
  logic [15:0] since_ref;
  logic        run_ref_seen;
  logic        mrs_seen;

  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_cmd  = (pin_cmd == CMD_PRE) || (pin_cmd == CMD_REF) || (pin_cmd == CMD_LMR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since        <= '0;
      need         <= '0;
      since_ref    <= '0;
      run_ref_seen <= 1'b0;
      mrs_seen     <= 1'b0;
    end else begin
      if (is_cmd) begin
        since <= 16'd1;
        if (pin_cmd == CMD_PRE)      need <= 16'(TRP_C);
        else if (pin_cmd == CMD_REF) need <= 16'(TRFC_C);
        else                         need <= 16'(TMRD_C);
      end else if (since != 16'hFFFF) begin
        since <= since + 1'b1;
      end
      if (pin_cmd == CMD_REF)         since_ref <= 16'd1;
      else if (since_ref != 16'hFFFF) since_ref <= since_ref + 1'b1;
      if (pin_cmd == CMD_REF && ready) run_ref_seen <= 1'b1;
      if (pin_cmd == CMD_LMR)          mrs_seen     <= 1'b1;
    end
  end

  // R1
  pwr_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> (sd_cs_n && !ready));

  // R2
  cke_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke |=> sd_cke);

  // R3
  pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_PRE) |-> sd_addr[10]);

  // R4
  ref_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ref |=> (pin_cmd == CMD_REF));

  // R5
  mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_LMR) |-> (sd_addr == ADDR_W'(MODE) && sd_ba == '0));

  // R5
  mrs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_mrs |=> (pin_cmd == CMD_LMR));

  // R6
  gap_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (since >= need));

  // R7
  ready_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R7
  ready_after_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> mrs_seen);

  // R8
  run_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_REF && ready && run_ref_seen) |-> (since_ref == 16'(RUN_PERIOD)));

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W),
  .TRP_C      (TRP_CYC),
  .TRFC_C     (TRFC_CYC),
  .TMRD_C     (TMRD_CYC),
  .RUN_PERIOD (RUN_UNITS * 16),
  .MODE       (MODE_WORD)
) u_chk (.*);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ   = 108;
  localparam int PWR   = 20;
  localparam int NOPW  = 30;
  localparam int BURST = 200;
  localparam int AW    = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, rdy;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(MHZ), .PWR_WAIT_CYC(PWR), .NOP_WAIT_CYC(NOPW), .BURST_WIN_CYC(BURST)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_addr(addr), .ready(rdy)
  );

  typedef struct {
    logic [3:0]   code;
    int           at;
    logic [AW-1:0] a;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_err = 0;
  int   edge_no;
  int   ready_edge = 1 << 30;
  int   run_period;
  bit   mon_on = 0;
  bit   done = 0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edge_no <= 0;
    else        edge_no <= edge_no + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // driver: predicts the command stream from the requirements
  task automatic push_sequence(input int n_run);
    int trp, trfc, p, last_ref, m, r;
    exp_t e;
    trp  = int'($ceil(24.0 * MHZ / 1000.0));
    trfc = int'($ceil(70.0 * MHZ / 1000.0));
    run_period = 16 * int'($floor(7513.0 * MHZ / 1000.0 / 16.0));
    exp_q.delete();
    p = PWR + NOPW;
    e.code = 4'b0010; e.at = p; e.a = AW'(1) << 10; e.tag = "R3";
    exp_q.push_back(e);
    last_ref = -1000;
    for (int t = p + 33; t <= p + BURST; t += 32) begin
      e.code = 4'b0001; e.at = t; e.a = '0; e.tag = "R4";
      exp_q.push_back(e);
      last_ref = t;
    end
    m = p + BURST + 1;
    if (last_ref + trfc > m) m = last_ref + trfc;
    if (p + trp > m) m = p + trp;
    e.code = 4'b0000; e.at = m; e.a = AW'('h033); e.tag = "R5";
    exp_q.push_back(e);
    r = m + 2;
    ready_edge = r;
    for (int j = 1; j <= n_run; j++) begin
      e.code = 4'b0001; e.at = r + 1 + run_period * j; e.a = '0; e.tag = "R8";
      exp_q.push_back(e);
    end
  endtask

  // monitor: compares pins against the prediction away from the clock edge
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      logic [3:0] code;
      exp_t e;
      code = {cs_n, ras_n, cas_n, we_n};
      chk(cke == (edge_no >= PWR), "R2", "cke", int'(cke), int'(edge_no >= PWR));
      chk(rdy == (edge_no >= ready_edge), "R7", "ready", int'(rdy), int'(edge_no >= ready_edge));
      if (edge_no < PWR)
        chk(code == 4'b1111, "R1", "inhibit cmd", int'(code), 15);
      else if (code == 4'b1111)
        chk(1'b0, "R9", "inhibit after cke", int'(code), 7);
      else if (code != 4'b0111) begin
        if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected cmd", int'(code), 7);
        else begin
          e = exp_q.pop_front();
          chk(code == e.code, e.tag, "cmd code", int'(code), int'(e.code));
          chk(edge_no == e.at, e.tag, "cmd edge", edge_no, e.at);
          if (e.code == 4'b0010) chk(addr[10] == 1'b1, "R3", "A10", int'(addr[10]), 1);
          if (e.code == 4'b0000) begin
            chk(addr == e.a, "R5", "mode word", int'(addr), int'(e.a));
            chk(ba == 2'b00, "R5", "bank", int'(ba), 0);
          end
        end
      end
    end
  end

  task automatic check_reset_state(input string tag);
    chk(cke == 1'b0, tag, "cke in reset", int'(cke), 0);
    chk(cs_n == 1'b1, tag, "cs_n in reset", int'(cs_n), 1);
    chk(rdy == 1'b0, tag, "ready in reset", int'(rdy), 0);
  endtask

  task automatic wait_edge(input int target);
    while (edge_no < target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1");

    // run 1: full sequence and three working refreshes
    push_sequence(3);
    mon_on = 1;
    rst_n = 1'b1;
    wait_edge(ready_edge + 3 * run_period + 40);
    chk(exp_q.size() == 0, "R8", "pending predictions", exp_q.size(), 0);
    chk(run_period * 1000 <= 7513 * MHZ, "R8", "interval ns*MHz", run_period * 1000, 7513 * MHZ);

    // R10: reset while running
    @(negedge clk);
    mon_on = 0;
    rst_n = 1'b0;
    #1;
    check_reset_state("R10");

    // R10: reset inside the refresh burst, then a clean restart
    @(negedge clk);
    rst_n = 1'b1;
    wait_edge(PWR + NOPW + 70);
    rst_n = 1'b0;
    #1;
    check_reset_state("R10");
    @(negedge clk);
    push_sequence(1);
    mon_on = 1;
    rst_n = 1'b1;
    wait_edge(ready_edge + run_period + 40);
    chk(exp_q.size() == 0, "R10", "restart predictions", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule